// File: doc/BRIEF.md
# Bus-Mapped Loop Counter Unit

This block is a loop-control functional unit that sits on a move-style transfer bus. It holds four subregisters: a running index, an end value, a per-pass increment and a loop-back address. Software prepares a loop in the usual way. It writes the end value, clears the index, sets the increment (one for a plain count) and stores the address of the loop body.

To close the loop, the program moves the branch subunit into the program counter. That read decides the branch inside the unit. It advances the index by the increment, compares the new index with the end value, and returns one of two values. While the loop still has passes left it returns the stored loop-back address. Once the loop has finished it returns the fall-through address, which the bus presents on a program-counter input. No CPU condition codes are involved.

Reads of the other subunits have no side effects. The bus is combinational on the read side: `rd_data` is valid in the same cycle as `rd_en`. Register updates take effect at the next rising clock edge.

Top module: `loop_counter_unit`

## Requirements
- R1: An active-low reset clears the index, end, increment and loop-back registers to zero.
- R2: A write with `wr_en` high loads `wr_data` into the subregister picked by `wr_sel`, taking effect at the next rising edge. The codes are 0 = index, 1 = end, 2 = increment, 3 = loop-back address.
- R3: A read with `rd_en` high and `rd_sel` of 0, 1 or 2 returns the index, end or increment register in the same cycle.
- R4: A read with `rd_sel` = 3 (the branch read) replaces the index with index + increment, modulo 2^DATA_W, at the next rising edge.
- R5: On a branch read, if (index + increment) is unsigned-below the end value, `rd_data` returns the stored loop-back address in the same cycle.
- R6: On a branch read, if (index + increment) is unsigned-equal to or above the end value, `rd_data` returns `pc_next` in the same cycle.
- R7: Reads with `rd_sel` of 0, 1 or 2 leave all registers unchanged, and a cycle with neither `rd_en` nor `wr_en` changes nothing.
- R8: When a write to the index coincides with a branch read, the written value wins. The branch result is computed from the register values held before that edge.
- R9: `rd_data` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the bus |
| wr_sel | input | 2 | Subregister written (0 index, 1 end, 2 increment, 3 loop-back) |
| wr_data | input | DATA_W | Value written |
| rd_en | input | 1 | Read strobe from the bus |
| rd_sel | input | 2 | Subregister read (3 is the branch read) |
| pc_next | input | DATA_W | Address of the instruction after the loop-closing move |
| rd_data | output | DATA_W | Value returned for the read |

## Verification
Two functions can land in the same cycle: a bus write into the index and the index advance caused by a branch read. The bench provokes this collision on purpose, both as a directed case and through random traffic that drives writes and branch reads together. A behavioural reference model, updated on every clock, judges the outcome. It expects the written value in the index afterwards and a branch result taken from the old index. The same model also covers the boundary where the advanced index lands exactly on the end value, overshoots it, or wraps past the top of the word.

// File: rtl/loop_counter_pkg.sv
package loop_counter_pkg;

  typedef enum logic [1:0] {
    SUB_INDEX  = 2'd0,
    SUB_LIMIT  = 2'd1,
    SUB_STRIDE = 2'd2,
    SUB_BRANCH = 2'd3
  } sub_sel_e;

  // Advanced index value, wrapping at the word size.
  function automatic logic [63:0] advance(input logic [63:0] idx,
                                          input logic [63:0] stride,
                                          input int unsigned width);
    logic [63:0] sum;
    logic [63:0] mask;
    sum  = idx + stride;
    mask = (width >= 64) ? {64{1'b1}} : ((64'd1 << width) - 64'd1);
    return sum & mask;
  endfunction

  // Completion test: the loop is over when the advanced index has
  // reached or passed the limit (unsigned view).
  function automatic logic finished_u(input logic [63:0] nxt,
                                      input logic [63:0] lim);
    return !(nxt < lim);
  endfunction

endpackage

// File: rtl/loop_param_regs.sv
module loop_param_regs
  import loop_counter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] limit_q,
  output logic [DATA_W-1:0] stride_q,
  output logic [DATA_W-1:0] target_q
);
  localparam int NREG = 3;

  logic [DATA_W-1:0] regs [NREG];
  logic [NREG-1:0]   hit;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      localparam logic [1:0] CODE = 2'(g + 1);
      assign hit[g] = wr_en && (wr_sel == CODE);
      always_ff @(posedge clk) begin
        if (!rst_n)      regs[g] <= '0;
        else if (hit[g]) regs[g] <= wr_data;
      end
    end
  endgenerate

  assign limit_q  = regs[0];
  assign stride_q = regs[1];
  assign target_q = regs[2];

  a_r2_write_loads_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SUB_LIMIT) |=> (limit_q == $past(wr_data)));

  a_r7_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(limit_q) && $stable(stride_q) && $stable(target_q));

  a_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/loop_index_reg.sv
module loop_index_reg
  import loop_counter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_write,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              step,
  input  logic [DATA_W-1:0] stride_q,
  output logic [DATA_W-1:0] index_q,
  output logic [DATA_W-1:0] index_adv
);
  assign index_adv = DATA_W'(advance(64'(index_q), 64'(stride_q), DATA_W));

  always_ff @(posedge clk) begin
    if (!rst_n)         index_q <= '0;
    else if (idx_write) index_q <= wr_data;
    else if (step)      index_q <= index_adv;
  end

  a_r4_step_adds_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_write) |=> (index_q == DATA_W'($past(index_q) + $past(stride_q))));

  a_r8_write_beats_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && idx_write) |=> (index_q == $past(wr_data)));

  a_r7_index_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !idx_write) |=> $stable(index_q));
endmodule

// File: rtl/loop_branch_sel.sv
module loop_branch_sel
  import loop_counter_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              branch_rd,
  input  logic [DATA_W-1:0] index_adv,
  input  logic [DATA_W-1:0] limit_q,
  input  logic [DATA_W-1:0] target_q,
  input  logic [DATA_W-1:0] pc_next,
  output logic              loop_done,
  output logic [DATA_W-1:0] branch_val
);
  generate
    if (SIGNED_CMP) begin : g_signed
      assign loop_done = !($signed(index_adv) < $signed(limit_q));
    end else begin : g_unsigned
      assign loop_done = finished_u(64'(index_adv), 64'(limit_q));
    end
  endgenerate

  assign branch_val = loop_done ? pc_next : target_q;

  a_r5_taken_returns_target: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_rd && !loop_done) |-> (branch_val == target_q));

  a_r6_done_returns_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_rd && loop_done) |-> (branch_val == pc_next));
endmodule

// File: rtl/loop_counter_unit.sv
module loop_counter_unit
  import loop_counter_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter bit SIGNED_CMP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic [DATA_W-1:0] pc_next,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] limit_q, stride_q, target_q;
  logic [DATA_W-1:0] index_q, index_adv, branch_val;
  logic              loop_done;

  // Named bus events
  logic idx_write;
  logic branch_rd;
  assign idx_write = wr_en && (wr_sel == SUB_INDEX);
  assign branch_rd = rd_en && (rd_sel == SUB_BRANCH);

  loop_param_regs #(.DATA_W(DATA_W)) u_params (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .limit_q (limit_q),
    .stride_q(stride_q),
    .target_q(target_q)
  );

  loop_index_reg #(.DATA_W(DATA_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_write(idx_write),
    .wr_data  (wr_data),
    .step     (branch_rd),
    .stride_q (stride_q),
    .index_q  (index_q),
    .index_adv(index_adv)
  );

  loop_branch_sel #(.DATA_W(DATA_W), .SIGNED_CMP(SIGNED_CMP)) u_branch (
    .clk       (clk),
    .rst_n     (rst_n),
    .branch_rd (branch_rd),
    .index_adv (index_adv),
    .limit_q   (limit_q),
    .target_q  (target_q),
    .pc_next   (pc_next),
    .loop_done (loop_done),
    .branch_val(branch_val)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (rd_sel)
        SUB_INDEX:  rd_data = index_q;
        SUB_LIMIT:  rd_data = limit_q;
        SUB_STRIDE: rd_data = stride_q;
        default:    rd_data = branch_val;
      endcase
    end
  end

  a_r9_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

  a_r3_index_read_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == SUB_INDEX) |-> (rd_data == index_q));
endmodule

// File: tb/loop_counter_unit_test.sv
module loop_counter_unit_test;
  localparam int    W          = 32;
  localparam time   CLK_PERIOD = 10;
  localparam int    WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = '0;
  logic [W-1:0] pc_next = '0;
  logic [W-1:0] rd_data;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference state
  logic [W-1:0] m_idx, m_end, m_inc, m_tgt;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_counter_unit #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .pc_next(pc_next), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] model_read(input logic re, input logic [1:0] rs,
                                              input logic [W-1:0] pc);
    longint unsigned nxt;
    if (!re) return '0;
    case (rs)
      2'd0: return m_idx;
      2'd1: return m_end;
      2'd2: return m_inc;
      default: begin
        nxt = (longint'(m_idx) + longint'(m_inc)) % (64'd1 << W);
        if (nxt < longint'(m_end)) return m_tgt;
        return pc;
      end
    endcase
  endfunction

  // One bus cycle: drive after the falling edge, compare, then let the
  // rising edge update both the design and the model.
  task automatic bus(input logic we, input logic [1:0] ws, input logic [W-1:0] wd,
                     input logic re, input logic [1:0] rs, input logic [W-1:0] pc,
                     input string req);
    logic [W-1:0] exp;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    rd_en = re; rd_sel = rs; pc_next = pc;
    #1;
    exp = model_read(re, rs, pc);
    check(req, rd_data, exp);
    @(posedge clk);
    // R8: write to the index overrides the branch step
    if (re && rs == 2'd3) m_idx = m_idx + m_inc;
    if (we) begin
      case (ws)
        2'd0: m_idx = wd;
        2'd1: m_end = wd;
        2'd2: m_inc = wd;
        default: m_tgt = wd;
      endcase
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [W-1:0] d);
    bus(1'b1, s, d, 1'b0, 2'd0, '0, "R2");
  endtask

  task automatic rd(input logic [1:0] s, input logic [W-1:0] pc, input string req);
    bus(1'b0, 2'd0, '0, 1'b1, s, pc, req);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    m_idx = '0; m_end = '0; m_inc = '0; m_tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: cleared after reset; R9: idle bus reads zero
    bus(1'b0, 2'd0, '0, 1'b0, 2'd0, '0, "R9");
    rd(2'd0, '0, "R1");
    rd(2'd1, '0, "R1");
    rd(2'd2, '0, "R1");
    rd(2'd0, '0, "R1");        // R6 next: 0+0 >= 0 -> fall-through
    rd(2'd3, 32'h0000_0040, "R6");

    // R2/R3: load and read back
    wr(2'd1, 32'd3); wr(2'd0, 32'd0); wr(2'd2, 32'd1); wr(2'd3, 32'h0000_0100);
    rd(2'd1, '0, "R3"); rd(2'd2, '0, "R3"); rd(2'd0, '0, "R3");

    // R4/R5/R6: three-pass loop, exact landing on the limit
    rd(2'd3, 32'h0000_0200, "R5");
    rd(2'd0, '0, "R4");
    rd(2'd3, 32'h0000_0200, "R5");
    rd(2'd3, 32'h0000_0200, "R6");
    rd(2'd0, '0, "R4");

    // R7: repeated side-effect-free reads
    rd(2'd0, '0, "R7"); rd(2'd1, '0, "R7"); rd(2'd0, '0, "R7");

    // Overshoot: stride 2, limit 5 -> 2,4 taken; 6 falls through (R6)
    wr(2'd0, 32'd0); wr(2'd2, 32'd2); wr(2'd1, 32'd5);
    rd(2'd3, 32'h11, "R5"); rd(2'd3, 32'h11, "R5"); rd(2'd3, 32'h11, "R6");
    rd(2'd0, '0, "R4");

    // Wrap: FFFFFFFF + 2 = 1 < 5 -> taken (R4 modulo)
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd3, 32'h22, "R5");
    rd(2'd0, '0, "R4");

    // R8: index write collides with branch read
    wr(2'd0, 32'd0);
    bus(1'b1, 2'd0, 32'd77, 1'b1, 2'd3, 32'h33, "R8");
    rd(2'd0, '0, "R8");
    // limit write colliding with branch read uses the old limit
    bus(1'b1, 2'd1, 32'd1000, 1'b1, 2'd3, 32'h44, "R8");
    rd(2'd1, '0, "R8");

    // Random mixed traffic checked against the model every cycle
    for (int i = 0; i < 400; i++) begin
      logic [1:0] ws, rs;
      logic [W-1:0] wd;
      ws = 2'($urandom_range(0, 3));
      rs = 2'($urandom_range(0, 3));
      wd = ($urandom_range(0, 3) == 0) ? W'($urandom) : W'($urandom_range(0, 12));
      bus(($urandom_range(0, 2) == 0), ws, wd,
          ($urandom_range(0, 3) != 0), rs, W'($urandom), "R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule